// File: doc/BRIEF.md
# Serial-Programmed Wiper Control Register

This block is the digital control core of a 128-position digital potentiometer. A host writes a 7-bit wiper code over a three-wire serial link made of an active-low frame select, a serial clock and a data line. Bits are shifted into a shift register, and the code is moved into a wiper latch when the frame select returns high. The latched code drives a one-hot 128-way tap select, where tap 0 is the B end of the ladder and each code step moves one tap toward A. Code 127 is the last tap, one step short of A.

All serial and control pins are sampled into a faster system clock domain and their edges are detected there, so the whole block is synchronous to `clk`. The one exception is the active-low preset input: it forces the wiper latch to midscale (0x40) and clears the shift register at once, even without a clock.

An active-low shutdown input does three things: it opens the terminal-A switch, shorts the wiper to B, and releases the serial output driver. Codes can still be shifted in and latched during shutdown, and the new code appears when shutdown ends. The serial output is a pull-down enable (open-drain equivalent). It passes on the most significant bit of the shift register, so two devices can be chained.

The frame sequencer has three states:
- ST_IDLE waits for the frame select to fall and then enters ST_FRAME.
- ST_FRAME shifts one bit on each detected serial-clock rise. When the frame select rises it enters ST_LOAD.
- ST_LOAD copies the shift register into the wiper latch for one cycle and returns to ST_IDLE.

Top module: `wiper_ctrl`

## Requirements
- R1: After a frame of 7 bits (most significant first) and a rising frame select, `tap_sel` has exactly bit N set, where N is the shifted code. Code 0 sets bit 0 (B end) and code 127 sets bit 127.
- R2: When more than 7 bits are clocked in one frame, only the last 7 bits received are loaded.
- R3: When fewer than 7 bits are clocked in a frame, the loaded code is the previous shift-register contents moved up by the number of new bits, with the new bits in the low positions.
- R4: The wiper latch does not change while bits are being shifted. It changes only after the frame select rises.
- R5: While `preset_n` is low, the wiper code is 0x40 (only `tap_sel[64]` set when awake) and the serial output bit is 0, so `ser_dout_pull` is 1 when awake.
- R6: Serial clock edges and frame-select rises that occur while `preset_n` is low change neither the shift register nor the wiper latch.
- R7: While `sleep_n` is low: `a_switch_en` is 0, `wb_short` is 1, `tap_sel` is all zero, and `ser_dout_pull` is 0.
- R8: A code written while `sleep_n` is low is latched and appears on `tap_sel` once `sleep_n` returns high. This gives a defined wiper value from an arbitrary power-up value.
- R9: The serial output bit is the bit that entered 7 serial clocks earlier (`ser_dout_pull` = 1 means the line is driven to 0). Two chained devices clocked 14 times in one frame hold the first 7 bits in the far device and the last 7 in the near device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; faster than the serial clock |
| rst_n | input | 1 | Active-low reset of synchronisers and sequencer |
| ser_cs_n | input | 1 | Active-low frame select; rising edge loads the wiper |
| ser_clk | input | 1 | Serial clock; data sampled on rising edge |
| ser_din | input | 1 | Serial data in, most significant bit first |
| preset_n | input | 1 | Active-low asynchronous preset to midscale |
| sleep_n | input | 1 | Active-low shutdown |
| ser_dout_pull | output | 1 | 1 = pull serial out line low; 0 = released |
| tap_sel | output | 128 | One-hot tap enable, bit 0 at the B end |
| a_switch_en | output | 1 | Terminal-A switch closed when 1 |
| wb_short | output | 1 | Wiper shorted to terminal B when 1 |

## Verification
The bench sweeps every one of the 128 codes and checks the one-hot tap and the serial-out bit after each frame. A wrong decode or a reversed bit order would set the wrong tap. It sends over-long and short frames: a design that keeps the first 7 bits, or that clears the register at frame start, loads a different code. It holds preset low while a full frame is clocked, so a design that lets shifting or loading through preset leaves the wiper away from 64. It also programs during shutdown and chains two devices over 14 clocks. An output that is one bit early or late, or a driver left on in shutdown, puts the wrong code in the far device.

// File: rtl/wiper_ctrl_pkg.sv
package wiper_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_LOAD  = 2'd2
    } frame_st_e;
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wiper_frame.sv
module wiper_frame
    import wiper_ctrl_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_n,
    input  logic              preset_s,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    output logic [CODE_W-1:0] wiper_code,
    output logic              out_bit
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    frame_st_e         state, state_nx;
    logic              cs_prev, sclk_prev;
    logic              cs_fall, cs_rise, sclk_rise;
    logic              shift_en, load_en;
    logic              sh_clr_n;
    logic [CODE_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_n_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_fall   = cs_prev && !cs_n_s;
    assign cs_rise   = !cs_prev && cs_n_s;
    assign sclk_rise = !sclk_prev && sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_nx = ST_FRAME;
            ST_FRAME: if (cs_rise) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state-decoded controls
    always_comb begin
        shift_en = 1'b0;
        load_en  = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_FRAME: shift_en = sclk_rise && preset_s;
            ST_LOAD:  load_en  = preset_s;
            default:  ;
        endcase
    end

    assign sh_clr_n = rst_n & preset_n;

    always_ff @(posedge clk or negedge sh_clr_n) begin
        if (!sh_clr_n)     sh <= '0;
        else if (shift_en) sh <= {sh[CODE_W-2:0], din_s};
    end

    // no power-up reset: the wiper starts at an arbitrary code
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)    wiper_code <= MID;
        else if (load_en) wiper_code <= sh;
    end

    assign out_bit = sh[CODE_W-1];

    AST_PRESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_s |-> wiper_code == MID); // R5

    AST_LOAD_ONLY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && $past(preset_n) && wiper_code != $past(wiper_code)) |-> $past(load_en)); // R4

    AST_SHIFT_LSB_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && preset_n) |=> (!preset_n || sh[0] == $past(din_s))); // R1

    AST_NO_SHIFT_IN_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_s && preset_n && $past(preset_n)) |-> $stable(sh)); // R6
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
    parameter int CODE_W = 7,
    parameter int TAPS   = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              awake,
    output logic [TAPS-1:0]   tap_sel
);
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_sel[i] = awake && (code == CODE_W'(i));
    end

    always_comb begin
        AST_TAP_ONEHOT: assert ($countones(tap_sel) == (awake ? 1 : 0)); // R1
    end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
    parameter int CODE_W      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 1 << CODE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_cs_n,
    input  logic            ser_clk,
    input  logic            ser_din,
    input  logic            preset_n,
    input  logic            sleep_n,
    output logic            ser_dout_pull,
    output logic [TAPS-1:0] tap_sel,
    output logic            a_switch_en,
    output logic            wb_short
);
    logic [4:0]        raw_in, syn_in;
    logic              cs_n_s, sclk_s, din_s, preset_s, sleep_s;
    logic [CODE_W-1:0] wiper_code;
    logic              out_bit;

    assign raw_in = {sleep_n, preset_n, ser_din, ser_clk, ser_cs_n};

    wiper_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11001)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {sleep_s, preset_s, din_s, sclk_s, cs_n_s} = syn_in;

    wiper_frame #(.CODE_W(CODE_W)) frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_n   (preset_n),
        .preset_s   (preset_s),
        .cs_n_s     (cs_n_s),
        .sclk_s     (sclk_s),
        .din_s      (din_s),
        .wiper_code (wiper_code),
        .out_bit    (out_bit)
    );

    wiper_tap_decode #(.CODE_W(CODE_W), .TAPS(TAPS)) dec_i (
        .code    (wiper_code),
        .awake   (sleep_s),
        .tap_sel (tap_sel)
    );

    assign a_switch_en   = sleep_s;
    assign wb_short      = !sleep_s;
    assign ser_dout_pull = sleep_s && !out_bit;

    AST_SLEEP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_s |-> (!ser_dout_pull && wb_short && !a_switch_en && tap_sel == '0)); // R7

    AST_AWAKE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_s |-> (a_switch_en && !wb_short && $countones(tap_sel) == 1)); // R8
endmodule

// File: tb/wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module wiper_ctrl_tb_top;
    localparam int TAPS = 128;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, preset_n = 1'b1, sleep_n = 1'b1;
    logic pull_n1, pull_f;
    logic [TAPS-1:0] tap_n1, tap_f;
    logic asw_n1, short_n1, asw_f, short_f;
    logic line_mid;
    int   n_tests = 0, n_fail = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    assign line_mid = ~pull_n1;

    wiper_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_clk(sclk), .ser_din(din),
        .preset_n(preset_n), .sleep_n(sleep_n), .ser_dout_pull(pull_n1),
        .tap_sel(tap_n1), .a_switch_en(asw_n1), .wb_short(short_n1)
    );

    wiper_ctrl far_i (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_clk(sclk), .ser_din(line_mid),
        .preset_n(preset_n), .sleep_n(sleep_n), .ser_dout_pull(pull_f),
        .tap_sel(tap_f), .a_switch_en(asw_f), .wb_short(short_f)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [127:0] tap_of(input int code, input bit awake);
        return awake ? (128'd1 << code) : 128'd0;
    endfunction

    task automatic frame_start;
        cs_n = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic shift_bit(input logic b);
        din = b;
        wait_cyc(HALF);
        sclk = 1'b1;
        wait_cyc(HALF);
        sclk = 1'b0;
    endtask

    task automatic frame_end;
        wait_cyc(HALF);
        cs_n = 1'b1;
        wait_cyc(10);
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        frame_start();
        for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
        frame_end();
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);

        // R8 / R7: program under shutdown from arbitrary power-up code
        sleep_n = 1'b0;
        wait_cyc(5);
        send(32'h15, 7);
        check("R7 tap", tap_n1, 128'd0);
        check("R7 switches", {asw_n1, short_n1, pull_n1}, {1'b0, 1'b1, 1'b0});
        sleep_n = 1'b1;
        wait_cyc(6);
        check("R8 code after release", tap_n1, tap_of(8'h15, 1));
        check("R8 switches", {asw_n1, short_n1}, {1'b1, 1'b0});

        // R5 / R6: preset with a full frame clocked during it
        preset_n = 1'b0;
        wait_cyc(2);
        check("R5 midscale async", tap_n1, tap_of(64, 1));
        send(32'h7F, 7);
        check("R5 midscale held", tap_n1, tap_of(64, 1));
        check("R5 out bit zero", {127'd0, line_mid}, 128'd0);
        preset_n = 1'b1;
        wait_cyc(6);
        check("R6 blocked frame", tap_n1, tap_of(64, 1));
        check("R6 shreg cleared", {127'd0, line_mid}, 128'd0);

        // R1 / R9: sweep every code
        for (int c = 0; c < 128; c++) begin
            send(32'(c), 7);
            check("R1 sweep", tap_n1, tap_of(c, 1));
            check("R9 out bit", {127'd0, line_mid}, {127'd0, c[6]});
        end

        // R4: latch unchanged during shifting
        frame_start();
        shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        wait_cyc(8);
        check("R4 mid-frame", tap_n1, tap_of(127, 1));
        shift_bit(1'b0); shift_bit(1'b0); shift_bit(1'b1);
        wait_cyc(8);
        check("R4 before cs rise", tap_n1, tap_of(127, 1));
        frame_end();
        check("R4 after cs rise", tap_n1, tap_of(7'b0101001, 1));

        // R2: 10-bit frame keeps last 7
        send(32'b11_0101_0011, 10);
        check("R2 long frame", tap_n1, tap_of(7'h53, 1));

        // R3: 3-bit frame shifts old contents up
        send(32'b101, 3);
        check("R3 short frame", tap_n1, tap_of(((7'h53 << 3) | 5) & 7'h7F, 1));

        // R9: two chained devices, 14 clocks
        send({18'd0, 7'h5A, 7'h23}, 14);
        check("R9 near device", tap_n1, tap_of(7'h23, 1));
        check("R9 far device", tap_f, tap_of(7'h5A, 1));

        // R7: chained far device sees released line during shutdown
        sleep_n = 1'b0;
        wait_cyc(5);
        check("R7 far tap", tap_f, 128'd0);
        check("R7 line released", {127'd0, line_mid}, 128'd1);
        sleep_n = 1'b1;
        wait_cyc(6);
        check("R8 far restored", tap_f, tap_of(7'h5A, 1));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule